// File: doc/BRIEF.md
# Credit-Gated Data-Strobe Link Transmitter

This block drives the outbound half of a serial point-to-point link. It sends a bit stream on a data/strobe wire pair: the data line carries each bit, and the strobe line flips whenever the data line keeps its value, so exactly one of the two lines changes per bit. A divisor register sets the bit period in system clocks and can be rewritten while the block runs.

Each outgoing unit is a character. A data character holds one byte. A control character holds a two-bit code. Every character opens with a parity bit and a flag, and the parity carries over from the character before. The block takes bytes and end-of-packet markers from a show-ahead FIFO. It sends them only while it holds credit granted by the far end's flow-control tokens. It inserts flow-control tokens and time codes when the link controller asks for them. With nothing it may send, it fills the line with NULL.

Top module: `ds_link_tx`

## Requirements
- R1: While `rst_n` is low, and on every cycle after a clock edge that saw `tx_en` low, `ds_d`, `ds_s` and `credit_err` are 0. `fifo_rd` and `fct_ack` stay 0 while `tx_en` is low.
- R2: The bit period is (divisor + 1) clock cycles. After reset the divisor is 2. Writing `rate_val` with `rate_wr` high loads a new divisor, which takes effect from the next bit period. The line holds still between bit instants.
- R3: At each bit instant exactly one of `ds_d`/`ds_s` changes. `ds_d` takes the bit value, and `ds_s` toggles when that value equals the previous `ds_d`.
- R4: Each character is sent as the parity bit, then the flag, then the payload least significant bit first. A data character has flag 0 and an 8-bit payload. A control character has flag 1 and a 2-bit code: FCT=0, EOP=1, EEP=2, ESC=3. A FIFO entry whose mark bit is set is sent as EOP when `fifo_data[0]` is 0 and as EEP when it is 1.
- R5: The parity bit makes odd the count of ones over the previous character's payload, the parity bit and the current flag. The history is empty after reset and after each enable.
- R6: A NULL (ESC then FCT) is sent whenever no other character may start. The first character after enable is therefore a NULL when nothing else is pending.
- R7: A character boundary serves, in order: the second half of a started NULL or time code, a pending time code, a requested FCT, a FIFO entry, and then NULL.
- R8: A FIFO entry is sent only when `data_mode` is high, `fifo_empty` is low and the credit is nonzero. `fifo_rd` is high for the one cycle before the edge that takes the entry, and each entry uses one credit.
- R9: Each `fct_rx` pulse adds 8 credits, up to a limit of 56. A pulse that would go past the limit adds nothing and sets `credit_err`, which stays set until `tx_en` goes low. Disabling clears the credit.
- R10: A `tick_wr` pulse adds one to a 6-bit time value, which wraps from 63 to 0, and stores `tick_flags`. It then queues a time code: ESC followed by a data character holding {flags, time}.
- R11: A held `fct_req` is served by one non-escaped FCT, and `fct_ack` is high for the one cycle before the edge at which that FCT starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Link enable from the exchange controller |
| data_mode | input | 1 | Allows FIFO entries to be sent |
| rate_wr | input | 1 | Loads the bit-rate divisor |
| rate_val | input | DIV_W | New divisor value |
| fifo_empty | input | 1 | Transmit FIFO has no entry |
| fifo_data | input | 8 | Head byte of the FIFO, or marker kind when marked |
| fifo_mark | input | 1 | Head entry is an end-of-packet marker |
| fifo_rd | output | 1 | Pops the FIFO head at the next edge |
| fct_req | input | 1 | Request to send one flow-control token |
| fct_ack | output | 1 | The request is served at the next edge |
| fct_rx | input | 1 | One flow-control token was received |
| tick_wr | input | 1 | Time-tick write strobe |
| tick_flags | input | 2 | Control flags for the time code |
| credit_err | output | 1 | Sticky credit overflow indication |
| ds_d | output | 1 | Data line |
| ds_s | output | 1 | Strobe line |

## Verification
The bench tries the link in five patterns: pure NULL fill with data withheld, a queued burst larger than the credit it holds, a stack of tokens that runs past the credit limit, a time-tick and token request raised together just after enable, and a long run of ticks that wraps the time value. Fill-only traffic separates the NULL pairing and parity chaining from any data path. The burst shows whether gating stops at exactly eight characters per token and resumes in order. The joint request shows whether time codes beat tokens and whether a started NULL is left whole. A second decoder rebuilds the characters from the wire pair. It checks parity and payload order against the bytes pushed in, and it counts line transitions at two divisor settings to pin down the bit period.

// File: rtl/ds_link_tx.sv
module ds_link_tx #(
  parameter int DIV_W       = 8,
  parameter int DIV_RESET   = 2,
  parameter int CREDIT_MAX  = 56,
  parameter int CREDIT_STEP = 8,
  parameter int TIME_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             data_mode,
  input  logic             rate_wr,
  input  logic [DIV_W-1:0] rate_val,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  input  logic             fifo_mark,
  output logic             fifo_rd,
  input  logic             fct_req,
  output logic             fct_ack,
  input  logic             fct_rx,
  input  logic             tick_wr,
  input  logic [1:0]       tick_flags,
  output logic             credit_err,
  output logic             ds_d,
  output logic             ds_s
);
  localparam int CW = $clog2(CREDIT_MAX + CREDIT_STEP + 1);
  localparam logic [1:0] C_FCT = 2'd0, C_EOP = 2'd1, C_EEP = 2'd2, C_ESC = 2'd3;
  localparam logic [1:0] F_NONE = 2'd0, F_FCT = 2'd1, F_TIME = 2'd2;

  logic [DIV_W-1:0]  div, cnt;
  logic [9:0]        sr, newc, curc;
  logic [3:0]        left;
  logic              prevx, par, is_data, take_t, bit_tick, load, fit;
  logic [CW-1:0]     credit;
  logic              cerr;
  logic              tpend;
  logic [TIME_W-1:0] tval;
  logic [1:0]        tflg, follow, fol_n, code;
  logic [7:0]        pay;

  assign bit_tick   = tx_en && (cnt == '0);
  assign load       = bit_tick && (left == 4'd0);
  assign fit        = (credit + CW'(CREDIT_STEP)) <= CW'(CREDIT_MAX);
  assign credit_err = cerr;

  always_comb begin
    is_data = 1'b0;
    pay     = '0;
    code    = C_ESC;
    fol_n   = F_NONE;
    take_t  = 1'b0;
    fct_ack = 1'b0;
    fifo_rd = 1'b0;
    if (follow == F_FCT) begin
      code = C_FCT;
    end else if (follow == F_TIME) begin
      is_data = 1'b1;
      pay     = 8'({tflg, tval});
    end else if (tpend) begin
      fol_n  = F_TIME;
      take_t = load;
    end else if (fct_req) begin
      code    = C_FCT;
      fct_ack = load;
    end else if (data_mode && !fifo_empty && credit != '0) begin
      fifo_rd = load;
      if (fifo_mark) code = fifo_data[0] ? C_EEP : C_EOP;
      else begin
        is_data = 1'b1;
        pay     = fifo_data;
      end
    end else begin
      fol_n = F_FCT;
    end
  end

  assign par  = ~(prevx ^ ~is_data);
  assign newc = is_data ? {pay, 1'b0, par} : {6'b0, code, 1'b1, par};
  assign curc = load ? newc : sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div    <= DIV_W'(DIV_RESET);
      cnt    <= '0;
      sr     <= '0;
      left   <= '0;
      prevx  <= 1'b0;
      ds_d   <= 1'b0;
      ds_s   <= 1'b0;
      credit <= '0;
      cerr   <= 1'b0;
      tpend  <= 1'b0;
      tval   <= '0;
      tflg   <= '0;
      follow <= F_NONE;
    end else begin
      if (rate_wr) div <= rate_val;
      if (tick_wr) begin
        tval <= tval + 1'b1;
        tflg <= tick_flags;
      end
      if (!tx_en) begin
        cnt    <= '0;
        sr     <= '0;
        left   <= '0;
        prevx  <= 1'b0;
        ds_d   <= 1'b0;
        ds_s   <= 1'b0;
        credit <= '0;
        cerr   <= 1'b0;
        tpend  <= 1'b0;
        follow <= F_NONE;
      end else begin
        cnt <= bit_tick ? div : cnt - 1'b1;
        if (bit_tick) begin
          ds_d <= curc[0];
          if (curc[0] == ds_d) ds_s <= ~ds_s;
          sr   <= curc >> 1;
          left <= (load ? (is_data ? 4'd10 : 4'd4) : left) - 4'd1;
        end
        if (load) begin
          follow <= fol_n;
          prevx  <= is_data ? ^pay : ^code;
        end
        if (tick_wr) tpend <= 1'b1;
        else if (take_t) tpend <= 1'b0;
        credit <= credit + ((fct_rx && fit) ? CW'(CREDIT_STEP) : CW'(0))
                         - (fifo_rd ? CW'(1) : CW'(0));
        if (fct_rx && !fit) cerr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ds_link_tx_chk.sv
module ds_link_tx_chk #(
  parameter int CW   = 7,
  parameter int CMAX = 56
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          bit_tick,
  input logic          ds_d,
  input logic          ds_s,
  input logic [CW-1:0] credit,
  input logic          credit_err,
  input logic          fifo_rd,
  input logic          fct_rx,
  input logic          fct_ack
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |=> (!ds_d && !ds_s && !credit_err)); // R1
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n) (tx_en && !bit_tick) |=> ($stable(ds_d) && $stable(ds_s))); // R2
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n) bit_tick |=> ($countones({ds_d ^ $past(ds_d), ds_s ^ $past(ds_s)}) == 1)); // R3
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({fifo_rd, fct_ack})); // R7
  AST_CREDIT_USED: assert property (@(posedge clk) disable iff (!rst_n) (fifo_rd && !fct_rx) |=> (credit == $past(credit) - 1'b1)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) credit <= CW'(CMAX)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (tx_en && credit_err) |=> credit_err); // R9
endmodule

bind ds_link_tx ds_link_tx_chk #(.CW(CW), .CMAX(CREDIT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
  .ds_d(ds_d), .ds_s(ds_s), .credit(credit), .credit_err(credit_err),
  .fifo_rd(fifo_rd), .fct_rx(fct_rx), .fct_ack(fct_ack)
);

// File: tb/ds_link_tx_test.sv
module ds_link_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, data_mode = 1'b0, rate_wr = 1'b0;
  logic [7:0] rate_val = '0;
  logic fifo_empty = 1'b1, fifo_mark = 1'b0, fifo_rd, fct_req = 1'b0, fct_ack;
  logic [7:0] fifo_data = '0;
  logic fct_rx = 1'b0, tick_wr = 1'b0, credit_err, ds_d, ds_s;
  logic [1:0] tick_flags = '0;

  ds_link_tx uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .data_mode(data_mode),
    .rate_wr(rate_wr), .rate_val(rate_val), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_mark(fifo_mark), .fifo_rd(fifo_rd),
    .fct_req(fct_req), .fct_ack(fct_ack), .fct_rx(fct_rx), .tick_wr(tick_wr),
    .tick_flags(tick_flags), .credit_err(credit_err), .ds_d(ds_d), .ds_s(ds_s)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string ph = "R1";

  // reference model state
  int m_div = 2, m_cnt = 0, m_credit = 0, m_time = 0, m_tflg = 0, m_follow = 0;
  bit m_d, m_s, m_prev, m_err, m_tpend, m_rd, m_ack, req_hold;
  bit m_bits[$];
  int fifo_q[$];
  int exp_rx[$];
  bit rd_s, ack_s;

  // wire decoder state
  bit dq[$];
  bit pd, ps, dpar, desc;
  int n_trans = 0, n_null = 0, n_fct = 0, n_eop = 0, n_eep = 0, n_tc = 0;
  int n_data = 0, n_parerr = 0, last_tc = -1, seq = 0, tc_seq = 0, fct_seq = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit xr(int v, int n);
    bit r = 0;
    for (int k = 0; k < n; k++) r ^= v[k];
    return r;
  endfunction

  task automatic model_edge();
    bit tk, isd, dec, b;
    int pay, nb, e, cr_old;
    m_rd = 0; m_ack = 0;
    if (!rst_n) begin
      m_div = 2; m_cnt = 0; m_credit = 0; m_time = 0; m_tflg = 0; m_follow = 0;
      m_d = 0; m_s = 0; m_prev = 0; m_err = 0; m_tpend = 0; m_bits.delete();
      return;
    end
    tk = tx_en && (m_cnt == 0);
    if (!tx_en) begin
      m_cnt = 0; m_bits.delete(); m_d = 0; m_s = 0; m_prev = 0;
      m_credit = 0; m_err = 0; m_tpend = 0; m_follow = 0;
    end else begin
      cr_old = m_credit; dec = 0;
      if (tk) begin
        if (m_bits.size() == 0) begin
          isd = 0; pay = 3;
          if (m_follow == 1) begin pay = 0; m_follow = 0; end
          else if (m_follow == 2) begin isd = 1; pay = m_tflg * 64 + m_time; m_follow = 0; end
          else if (m_tpend) begin pay = 3; m_follow = 2; m_tpend = 0; end
          else if (fct_req) begin pay = 0; m_ack = 1; req_hold = 0; end
          else if (data_mode && fifo_q.size() > 0 && m_credit > 0) begin
            e = fifo_q.pop_front(); m_rd = 1; dec = 1;
            if (e >= 256) pay = (e % 2 == 1) ? 2 : 1;
            else begin isd = 1; pay = e; end
          end else begin pay = 3; m_follow = 1; end
          nb = isd ? 8 : 2;
          m_bits.push_back(1 ^ m_prev ^ !isd);
          m_bits.push_back(!isd);
          for (int k = 0; k < nb; k++) m_bits.push_back(pay[k]);
          m_prev = xr(pay, nb);
        end
        b = m_bits.pop_front();
        if (b == m_d) m_s = !m_s;
        m_d = b;
        m_cnt = m_div;
      end else m_cnt--;
      if (fct_rx) begin
        if (cr_old + 8 > 56) m_err = 1;
        else m_credit += 8;
      end
      if (dec) m_credit--;
      if (tick_wr) m_tpend = 1;
    end
    if (rate_wr) m_div = rate_val;
    if (tick_wr) begin m_time = (m_time + 1) % 64; m_tflg = tick_flags; end
  endtask

  task automatic decode();
    int need, val;
    bit p, f;
    if (!tx_en) begin
      dq.delete(); dpar = 0; desc = 0; pd = 0; ps = 0;
      return;
    end
    if (ds_d == pd && ds_s == ps) return;
    n_trans++;
    dq.push_back(ds_d); pd = ds_d; ps = ds_s;
    if (dq.size() < 2) return;
    need = dq[1] ? 4 : 10;
    if (dq.size() != need) return;
    p = dq[0]; f = dq[1]; val = 0;
    for (int k = 2; k < need; k++) if (dq[k]) val += (1 << (k - 2));
    if ((dpar ^ p ^ f) != 1'b1) n_parerr++;
    dpar = xr(val, need - 2);
    seq++;
    if (f) begin
      if (desc) begin
        if (val == 0) n_null++;
        desc = 0;
      end else if (val == 0) begin n_fct++; fct_seq = seq; end
      else if (val == 1) n_eop++;
      else if (val == 2) n_eep++;
      else desc = 1;
    end else if (desc) begin
      last_tc = val; n_tc++; tc_seq = seq; desc = 0;
    end else begin
      n_data++;
      if (exp_rx.size() > 0) begin
        int x = exp_rx.pop_front();
        chk(val == x, "R4 data byte order", val, x);
      end else chk(0, "R4 unexpected data byte", val, -1);
    end
    dq.delete();
  endtask

  task automatic drive_fifo();
    fifo_empty = (fifo_q.size() == 0);
    fifo_data  = fifo_empty ? 8'd0 : 8'(fifo_q[0] % 256);
    fifo_mark  = !fifo_empty && (fifo_q[0] >= 256);
  endtask

  task automatic step();
    int act, exp;
    #2;
    rd_s = fifo_rd; ack_s = fct_ack;
    @(negedge clk);
    model_edge();
    act = {ds_d, ds_s, credit_err, rd_s, ack_s};
    exp = {m_d, m_s, m_err, m_rd, m_ack};
    chk(act == exp, {ph, " cycle compare {d,s,err,rd,ack}"}, act, exp);
    decode();
    drive_fifo();
    fct_req = req_hold;
    #1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic push(int v);
    fifo_q.push_back(v);
    if (v < 256) exp_rx.push_back(v);
    drive_fifo();
  endtask

  initial begin
    int t0;
    run(4);
    rst_n = 1'b1;
    run(3);
    chk({ds_d, ds_s, credit_err, fifo_rd, fct_ack} == 0, "R1 idle after reset", {ds_d, ds_s, credit_err, fifo_rd, fct_ack}, 0);

    ph = "R6"; tx_en = 1'b1;
    run(80);
    chk(n_null > 0, "R6 NULL fill present", n_null, 1);
    chk(n_data == 0, "R6 no data without mode", n_data, 0);

    ph = "R2"; rate_val = 8'd0; rate_wr = 1'b1; step(); rate_wr = 1'b0;
    run(10);
    t0 = n_trans; run(40);
    chk(n_trans - t0 == 40, "R2 R3 transitions at divisor 0", n_trans - t0, 40);

    ph = "R8"; data_mode = 1'b1;
    for (int i = 0; i < 20; i++) push((i * 37 + 5) % 256);
    push(256);
    for (int i = 0; i < 3; i++) push(200 + i);
    push(257);
    run(100);
    chk(n_data == 0, "R8 no data without credit", n_data, 0);
    fct_rx = 1'b1; step(); fct_rx = 1'b0;
    run(300);
    chk(n_data == 8, "R8 one token releases eight", n_data, 8);
    for (int i = 0; i < 3; i++) begin fct_rx = 1'b1; step(); fct_rx = 1'b0; step(); end
    run(400);
    chk(n_data == 23, "R8 all bytes sent", n_data, 23);
    chk(n_eop == 1 && n_eep == 1, "R4 marker codes", n_eop * 10 + n_eep, 11);

    ph = "R9";
    for (int i = 0; i < 6; i++) begin fct_rx = 1'b1; step(); fct_rx = 1'b0; step(); end
    chk(credit_err == 1'b0, "R9 no error up to limit", credit_err, 0);
    fct_rx = 1'b1; step(); fct_rx = 1'b0; step();
    chk(credit_err == 1'b1, "R9 error past limit", credit_err, 1);
    run(20);
    chk(credit_err == 1'b1, "R9 error sticky", credit_err, 1);
    tx_en = 1'b0; run(3);
    chk({credit_err, ds_d, ds_s} == 0, "R9 R1 cleared on disable", {credit_err, ds_d, ds_s}, 0);

    ph = "R7"; tx_en = 1'b1;
    for (int i = 0; i < 4; i++) push(60 + i);
    step();
    tick_wr = 1'b1; tick_flags = 2'b10; req_hold = 1'b1; fct_req = 1'b1;
    step(); tick_wr = 1'b0;
    run(60);
    chk(n_tc == 1 && last_tc == 129, "R10 time code value", last_tc, 129);
    chk(n_fct == 1, "R11 one token for request", n_fct, 1);
    chk(tc_seq < fct_seq, "R7 time code before token", tc_seq, fct_seq);
    fct_rx = 1'b1; step(); fct_rx = 1'b0;
    run(100);
    chk(n_data == 27, "R8 bytes after re-enable", n_data, 27);

    ph = "R10"; tick_wr = 1'b1; run(63); tick_wr = 1'b0;
    run(100);
    chk(last_tc == 128, "R10 time wraps to zero", last_tc, 128);

    ph = "R2"; rate_val = 8'd4; rate_wr = 1'b1; step(); rate_wr = 1'b0;
    run(20);
    t0 = n_trans; run(50);
    chk(n_trans - t0 == 10, "R2 R3 transitions at divisor 4", n_trans - t0, 10);
    run(100);
    chk(n_parerr == 0, "R5 parity chain", n_parerr, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule